// File: doc/BRIEF.md
# Event Interrupt Aggregator with End-of-Interrupt Re-arm

This block gathers eight single-cycle event pulses from two DMA channels into sticky status bits. Four events come from channel I and four from channel Q. A mask held in the block filters those bits. Whenever a filtered bit is pending and the output is armed, the block raises one combined CPU interrupt pulse. Software changes the mask through two registers. Writing ones to one of them turns bits on, and writing ones to the other turns bits off, so no read-modify-write is needed.

After each interrupt pulse the output stays blocked until software writes zero to the end-of-interrupt register. Events that arrive in the meantime are still recorded in status. The handler therefore sees every event, even when one pulse stands for several of them. If enabled status is still pending when the end-of-interrupt write lands, a fresh pulse follows at once.

The register port is a single-cycle port. Writes take effect at the clock edge, and read data is combinational from the address.

Top module: `evt_irq_agg`

## Requirements
- R1: After reset, raw status, enable mask and enabled status all read 0, `irq_o` is low, and the output is armed.
- R2: An event pulse on `evt_i[k]` sets raw status bit k (address 0) at the next clock edge, whether or not bit k is enabled. Bits 3:0 belong to channel I and bits 7:4 to channel Q.
- R3: Writing to address 2 ORs the write data into the enable mask. Zero bits in the data leave the mask unchanged.
- R4: Writing to address 3 clears every enable bit that is 1 in the write data. Other bits are left unchanged.
- R5: A read of address 2 or address 3 returns the current enable mask.
- R6: A read of address 1 returns raw status AND enable mask. Writes to address 1 have no effect.
- R7: Writing 1 to a bit at address 0 clears that raw status bit. If an event on the same bit arrives in the same cycle, the event wins and the bit stays set.
- R8: When the output is armed and enabled status is nonzero, `irq_o` is high for exactly one cycle, and the output then becomes blocked.
- R9: While blocked, further events are recorded in raw and enabled status but raise no new `irq_o` pulse.
- R10: Writing 8'h00 to address 4 re-arms the output. If enabled status is then nonzero, `irq_o` pulses in the cycle after the write edge. A nonzero write to address 4 is ignored.
- R11: Events whose enable bit is 0 never raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event pulses; [3:0] channel I, [7:4] channel Q |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address (0 raw, 1 enabled status, 2 enable set, 3 enable clear, 4 end of interrupt) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Combined interrupt, one-cycle pulse |

## Verification
The assertions check several rules on every cycle:
- a pending event always lands in raw status;
- raw bits are only lost through a clear write;
- set and clear writes move the mask as stated;
- a pulse lasts one cycle;
- no pulse appears between a pulse and the next end-of-interrupt write.

Only the bench scenarios can show the rest. These are the read views at each address, the event-wins-over-clear collision, the ignored writes to enabled status and nonzero end-of-interrupt data, the immediate re-pulse when status is still pending at the end-of-interrupt write, and the silence of masked events.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RAW    = 3'd0,
    SEL_ENSTAT = 3'd1,
    SEL_ENSET  = 3'd2,
    SEL_ENCLR  = 3'd3,
    SEL_EOI    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/evt_raw_status.sv
module evt_raw_status #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] raw_o
);
  for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        bit_q <= 1'b0;
      else if (evt_i[k])  bit_q <= 1'b1;  // event beats clear
      else if (clr_i[k])  bit_q <= 1'b0;
    end
    assign raw_o[k] = bit_q;
  end
endmodule

// File: rtl/evt_enable_mask.sv
module evt_enable_mask #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] set_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] en_o
);
  logic [NUM_EVT-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_i) & ~clr_i;
  end

  assign en_o = en_q;
endmodule

// File: rtl/irq_arm_gate.sv
module irq_arm_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pend_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic armed_q;
  logic fire;

  assign fire = armed_q & pend_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b1;
    else if (eoi_i) armed_q <= 1'b1;
    else if (fire)  armed_q <= 1'b0;
  end

  assign irq_o = fire;
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 2,
  parameter int unsigned EVT_PER_CH = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_CH*EVT_PER_CH-1:0]  evt_i,
  input  logic                          reg_we_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic [NUM_CH*EVT_PER_CH-1:0]  reg_wdata_i,
  output logic [NUM_CH*EVT_PER_CH-1:0]  reg_rdata_o,
  output logic                          irq_o
);
  localparam int unsigned NUM_EVT = NUM_CH * EVT_PER_CH;

  logic [NUM_EVT-1:0] raw_q, en_q, en_stat;
  logic [NUM_EVT-1:0] raw_clr, en_set, en_clr;
  logic               eoi_wr;

  always_comb begin
    raw_clr = '0;
    en_set  = '0;
    en_clr  = '0;
    eoi_wr  = 1'b0;
    if (reg_we_i) begin
      unique case (reg_addr_i)
        SEL_RAW:   raw_clr = reg_wdata_i;
        SEL_ENSET: en_set  = reg_wdata_i;
        SEL_ENCLR: en_clr  = reg_wdata_i;
        SEL_EOI:   eoi_wr  = (reg_wdata_i == '0);
        default:   ;
      endcase
    end
  end

  evt_raw_status #(.NUM_EVT(NUM_EVT)) u_raw (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .clr_i (raw_clr),
    .raw_o (raw_q)
  );

  evt_enable_mask #(.NUM_EVT(NUM_EVT)) u_en (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (en_set),
    .clr_i (en_clr),
    .en_o  (en_q)
  );

  assign en_stat = raw_q & en_q;

  irq_arm_gate u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pend_i(|en_stat),
    .eoi_i (eoi_wr),
    .irq_o (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      SEL_RAW:              reg_rdata_o = raw_q;
      SEL_ENSTAT:           reg_rdata_o = en_stat;
      SEL_ENSET, SEL_ENCLR: reg_rdata_o = en_q;
      default:              reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               reg_we_i,
  input logic [ADDR_W-1:0]  reg_addr_i,
  input logic [NUM_EVT-1:0] reg_wdata_i,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] raw_q,
  input logic [NUM_EVT-1:0] en_q
);
  logic wr_raw, wr_set, wr_clr, wr_eoi, blocked_q;

  assign wr_raw = reg_we_i && (reg_addr_i == SEL_RAW);
  assign wr_set = reg_we_i && (reg_addr_i == SEL_ENSET);
  assign wr_clr = reg_we_i && (reg_addr_i == SEL_ENCLR);
  assign wr_eoi = reg_we_i && (reg_addr_i == SEL_EOI) && (reg_wdata_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     blocked_q <= 1'b0;
    else if (wr_eoi) blocked_q <= 1'b0;
    else if (irq_o)  blocked_q <= 1'b1;
  end

  AST_EVT_CAPTURED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i != '0) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));  // R2

  AST_RAW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_raw |=> ((raw_q & $past(raw_q)) == $past(raw_q)));  // R7

  AST_EN_SET_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));  // R3

  AST_EN_CLR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_q & $past(reg_wdata_i)) == '0));  // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_eoi) |=> !irq_o);  // R8

  AST_NO_REFIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_q |-> !irq_o);  // R9
endmodule

bind evt_irq_agg evt_irq_agg_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .raw_q      (raw_q),
  .en_q       (en_q)
);

// File: tb/sim_evt_irq_agg.sv
module sim_evt_irq_agg;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WDOG_CYC   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt = '0;
  logic       we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_irq_agg u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .evt_i      (evt),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    check(rdata == exp, req, rdata, exp);
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic t_reset;
    rd_chk(3'd0, 8'h00, "R1 raw");
    rd_chk(3'd2, 8'h00, "R1 en");
    rd_chk(3'd1, 8'h00, "R1 enstat");
    check(irq == 1'b0, "R1 irq", irq, 0);
  endtask

  task automatic t_raw_capture;
    pulse(8'hA5);
    check(irq == 1'b0, "R11 masked no irq", irq, 0);
    rd_chk(3'd0, 8'hA5, "R2 raw both channels");
    rd_chk(3'd1, 8'h00, "R6 enstat masked");
  endtask

  task automatic t_w1c;
    wr(3'd0, 8'h05);
    rd_chk(3'd0, 8'hA0, "R7 w1c");
    @(negedge clk);
    we = 1'b1; addr = 3'd0; wdata = 8'h80; evt = 8'h80;
    @(negedge clk);
    we = 1'b0; evt = '0;
    rd_chk(3'd0, 8'hA0, "R7 event wins");
    wr(3'd0, 8'hFF);
    rd_chk(3'd0, 8'h00, "R7 clear all");
  endtask

  task automatic t_enable;
    wr(3'd2, 8'h0F);
    rd_chk(3'd2, 8'h0F, "R5 read set addr");
    rd_chk(3'd3, 8'h0F, "R5 read clr addr");
    wr(3'd2, 8'h30);
    rd_chk(3'd2, 8'h3F, "R3 set or");
    wr(3'd3, 8'h05);
    rd_chk(3'd3, 8'h3A, "R4 clr");
    pulse(8'h01);
    check(irq == 1'b0, "R11 disabled bit", irq, 0);
    rd_chk(3'd1, 8'h00, "R6 enstat");
    wr(3'd1, 8'hFF);
    rd_chk(3'd1, 8'h00, "R6 write ignored");
    rd_chk(3'd0, 8'h01, "R6 raw untouched");
    rd_chk(3'd2, 8'h3A, "R6 mask untouched");
    wr(3'd0, 8'hFF);
  endtask

  task automatic t_irq;
    pulse(8'h02);
    check(irq == 1'b1, "R8 pulse", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 one cycle", irq, 0);
    pulse(8'h08);
    check(irq == 1'b0, "R9 blocked", irq, 0);
    rd_chk(3'd1, 8'h0A, "R9 enstat kept");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(irq == 1'b0, "R9 stays blocked", irq, 0);
    end
    wr(3'd4, 8'h01);
    check(irq == 1'b0, "R10 nonzero eoi ignored", irq, 0);
    wr(3'd4, 8'h00);
    check(irq == 1'b1, "R10 repulse", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R10 repulse one cycle", irq, 0);
    wr(3'd0, 8'hFF);
    wr(3'd4, 8'h00);
    check(irq == 1'b0, "R10 no pending", irq, 0);
    pulse(8'h01);
    check(irq == 1'b0, "R11 masked after eoi", irq, 0);
    pulse(8'h10);
    check(irq == 1'b1, "R8 channel Q event", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, "R8 one cycle Q", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raw_capture();
    t_w1c();
    t_enable();
    t_irq();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WDOG_CYC && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog act=0 exp=1");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule